// File: doc/BRIEF.md
# Dual-Mode FIFO Read Stage

This block is the control stage that sits between a FIFO storage array and its consumer. It keeps the write and read pointers and drives the address and strobe lines of an external memory. That memory has a registered write port and a combinational read port. The block also owns the output data register and produces one flag for each side. The storage itself lives outside the block. Each pointer reaches the opposite side through a Gray-coded synchroniser with a parameterised number of stages. This gives the flags the two-cycle cross-side lag of a dual-clock buffer, while both sides here share one clock.

The read behaviour is chosen by a mode pin, and the pin is looked at only while reset is held. With the pin low, the stage runs in explicit-read mode. No word reaches the output without a read request, the read-side flag is an active-low empty indication and the write-side flag is an active-low full indication. With the pin high, the stage runs in fall-through mode. The oldest word is preloaded into the output register without any request, the read-side flag is high while the output holds no valid word, and the write-side flag is high while no space is free. The output register counts as one extra storage slot in this mode. A read request needs both the read enable and the read select driven low.

Top module: `dualmode_rd_stage`

## Requirements
- R1: The mode is captured from `mode_pin` on every clock edge while `rst` is high (0 = explicit-read, 1 = fall-through) and is held unchanged after reset, whatever `mode_pin` does.
- R2: In explicit-read mode, after reset `flag_rd` is 0 (empty) and `flag_wr` is 1 (not full). `flag_wr` goes to 0 on the edge that stores the word filling all 2^ADDR_W memory slots.
- R3: In fall-through mode, after reset `flag_rd` is 1 (no valid output) and `flag_wr` is 0. `flag_wr` goes to 1 when the memory slots and the output register all hold words (2^ADDR_W + 1 words).
- R4: In fall-through mode, a word written into an empty stage appears on `rd_data` with `flag_rd` at 0 after the third rising clock edge that follows the write edge, with no read request.
- R5: A read request exists only when `rd_en_n` and `rd_cs_n` are both 0. Without a request, `rd_data` keeps its value, and in fall-through mode a valid output word stays valid.
- R6: A read request while no word is available leaves `rd_data` unchanged. A write (`wr_en_n` = 0) while the write-side flag shows full is dropped and never appears at the output.
- R7: In fall-through mode, the read request that consumes the last stored word makes `flag_rd` 1 after that edge.
- R8: In explicit-read mode, `flag_rd` goes to 1 two clock edges after the write edge that made data available. `flag_wr` returns to 1 two clock edges after the read edge that freed a slot.
- R9: Words leave in the order they were accepted, in both modes, under any mix of writes and reads.
- R10: In explicit-read mode, `rd_data` takes the next word on the clock edge of a read request made while `flag_rd` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by write and read sides |
| rst | input | 1 | Synchronous active-high reset; mode is captured while high |
| mode_pin | input | 1 | Mode select, sampled only during reset (0 explicit-read, 1 fall-through) |
| wr_en_n | input | 1 | Active-low write request |
| wr_data | input | DATA_W | Word to store |
| rd_en_n | input | 1 | Active-low read enable |
| rd_cs_n | input | 1 | Active-low read select |
| mem_wr_en | output | 1 | Memory write strobe for an accepted write |
| mem_wr_addr | output | ADDR_W | Memory write address |
| mem_wr_data | output | DATA_W | Memory write data |
| mem_rd_en | output | 1 | Memory read strobe, high in the cycle a word is taken |
| mem_rd_addr | output | ADDR_W | Memory read address (combinational read) |
| mem_rd_data | input | DATA_W | Memory read data for `mem_rd_addr` |
| rd_data | output | DATA_W | Output data register |
| flag_rd | output | 1 | Empty (explicit-read, active low) or output-not-ready (fall-through, active high) |
| flag_wr | output | 1 | Full (explicit-read, active low) or input-not-ready (fall-through, active high) |

## Verification
The bench builds the block with ADDR_W = 3 and DATA_W = 18, so the memory holds eight words. Reaching the full condition takes only eight writes in explicit-read mode and nine in fall-through mode. This puts the full flag, the dropped write, the two-edge flag recovery and the draining of the last word within a few dozen cycles of each directed test. The random phases in both modes then pass through full and empty repeatedly with a two-stage synchroniser.

// File: rtl/drs_pkg.sv
package drs_pkg;

    typedef enum logic {
        MODE_STD  = 1'b0,
        MODE_FWFT = 1'b1
    } rd_mode_e;

    typedef struct packed {
        logic rd_side;
        logic wr_side;
    } flag_pair_t;

    // Flag meaning and polarity depend on the latched mode.
    function automatic flag_pair_t encode_flags(
        input rd_mode_e mode,
        input logic     avail,
        input logic     out_valid,
        input logic     full
    );
        flag_pair_t f;
        if (mode == MODE_STD) begin
            f.rd_side = avail;      // low means empty
            f.wr_side = !full;      // low means full
        end else begin
            f.rd_side = !out_valid; // high means nothing valid at output
            f.wr_side = full;       // high means no space
        end
        return f;
    endfunction

endpackage

// File: rtl/drs_ptr_sync.sv
module drs_ptr_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] bin_in,
    output logic [W-1:0] bin_out
);

    logic [W-1:0] gray_in;
    logic [W-1:0] stg [STAGES];

    assign gray_in = bin_in ^ (bin_in >> 1);

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        if (s == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) stg[0] <= '0;
                else     stg[0] <= gray_in;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) stg[s] <= '0;
                else     stg[s] <= stg[s-1];
            end
        end
    end

    always_comb begin
        for (int i = 0; i < W; i++) begin
            bin_out[i] = ^(stg[STAGES-1] >> i);
        end
    end

endmodule

// File: rtl/drs_wr_ctrl.sv
module drs_wr_ctrl #(
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en_n,
    input  logic [ADDR_W:0]   rptr_sync,
    output logic [ADDR_W:0]   wptr,
    output logic              full,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr
);

    localparam int PTR_W = ADDR_W + 1;
    localparam logic [PTR_W-1:0] DEPTH_P = PTR_W'(1) << ADDR_W;

    logic [PTR_W-1:0] wptr_q;
    logic             accept;
    logic [PTR_W-1:0] fill;

    assign full   = (wptr_q[ADDR_W] != rptr_sync[ADDR_W]) &&
                    (wptr_q[ADDR_W-1:0] == rptr_sync[ADDR_W-1:0]);
    assign accept = !wr_en_n && !full;
    assign fill   = wptr_q - rptr_sync;

    always_ff @(posedge clk) begin
        if (rst)         wptr_q <= '0;
        else if (accept) wptr_q <= wptr_q + PTR_W'(1);
    end

    assign wptr        = wptr_q;
    assign mem_wr_en   = accept;
    assign mem_wr_addr = wptr_q[ADDR_W-1:0];

    p_no_overflow_r6: assert property (@(posedge clk) disable iff (rst)
        full |=> $stable(wptr_q));

    p_fill_bound_r2: assert property (@(posedge clk) disable iff (rst)
        fill <= DEPTH_P);

endmodule

// File: rtl/drs_rd_ctrl.sv
module drs_rd_ctrl
    import drs_pkg::*;
#(
    parameter int DATA_W = 18,
    parameter int ADDR_W = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  rd_mode_e          mode,
    input  logic              rd_en_n,
    input  logic              rd_cs_n,
    input  logic [ADDR_W:0]   wptr_sync,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [ADDR_W:0]   rptr,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_valid,
    output logic              avail
);

    localparam int PTR_W = ADDR_W + 1;

    logic [PTR_W-1:0]  rptr_q;
    logic [DATA_W-1:0] data_q;
    logic              valid_q;
    logic              rd_req;
    logic              load;

    assign rd_req = !rd_en_n && !rd_cs_n;
    assign avail  = (wptr_sync != rptr_q);

    always_comb begin
        if (mode == MODE_STD) load = rd_req && avail;
        else                  load = avail && (!valid_q || rd_req);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rptr_q  <= '0;
            data_q  <= '0;
            valid_q <= 1'b0;
        end else if (load) begin
            rptr_q  <= rptr_q + PTR_W'(1);
            data_q  <= mem_rd_data;
            valid_q <= (mode == MODE_FWFT);
        end else if (rd_req) begin
            valid_q <= 1'b0;
        end
    end

    assign rptr        = rptr_q;
    assign mem_rd_en   = load;
    assign mem_rd_addr = rptr_q[ADDR_W-1:0];
    assign rd_data     = data_q;
    assign out_valid   = valid_q;

    p_no_underflow_r6: assert property (@(posedge clk) disable iff (rst)
        !avail |=> $stable(rptr_q));

    p_std_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_STD && (rd_en_n || rd_cs_n)) |=> $stable(data_q));

    p_fwft_hold_r5: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && valid_q && (rd_en_n || rd_cs_n))
            |=> ($stable(data_q) && valid_q));

    p_last_read_r7: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_FWFT && valid_q && rd_req && !avail) |=> !valid_q);

endmodule

// File: rtl/dualmode_rd_stage.sv
module dualmode_rd_stage
    import drs_pkg::*;
#(
    parameter int DATA_W      = 18,
    parameter int ADDR_W      = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_pin,
    input  logic              wr_en_n,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en_n,
    input  logic              rd_cs_n,
    output logic              mem_wr_en,
    output logic [ADDR_W-1:0] mem_wr_addr,
    output logic [DATA_W-1:0] mem_wr_data,
    output logic              mem_rd_en,
    output logic [ADDR_W-1:0] mem_rd_addr,
    input  logic [DATA_W-1:0] mem_rd_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              flag_rd,
    output logic              flag_wr
);

    localparam int PTR_W = ADDR_W + 1;

    rd_mode_e         mode_q;
    logic [PTR_W-1:0] wptr, rptr, wptr_sync, rptr_sync;
    logic             full, avail, out_valid;
    flag_pair_t       flags;

    always_ff @(posedge clk) begin
        if (rst) mode_q <= rd_mode_e'(mode_pin);
    end

    drs_wr_ctrl #(.ADDR_W(ADDR_W)) u_wr (
        .clk         (clk),
        .rst         (rst),
        .wr_en_n     (wr_en_n),
        .rptr_sync   (rptr_sync),
        .wptr        (wptr),
        .full        (full),
        .mem_wr_en   (mem_wr_en),
        .mem_wr_addr (mem_wr_addr)
    );

    drs_ptr_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_w2r (
        .clk     (clk),
        .rst     (rst),
        .bin_in  (wptr),
        .bin_out (wptr_sync)
    );

    drs_ptr_sync #(.W(PTR_W), .STAGES(SYNC_STAGES)) u_r2w (
        .clk     (clk),
        .rst     (rst),
        .bin_in  (rptr),
        .bin_out (rptr_sync)
    );

    drs_rd_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_rd (
        .clk         (clk),
        .rst         (rst),
        .mode        (mode_q),
        .rd_en_n     (rd_en_n),
        .rd_cs_n     (rd_cs_n),
        .wptr_sync   (wptr_sync),
        .mem_rd_data (mem_rd_data),
        .rptr        (rptr),
        .mem_rd_en   (mem_rd_en),
        .mem_rd_addr (mem_rd_addr),
        .rd_data     (rd_data),
        .out_valid   (out_valid),
        .avail       (avail)
    );

    assign mem_wr_data = wr_data;
    assign flags       = encode_flags(mode_q, avail, out_valid, full);
    assign flag_rd     = flags.rd_side;
    assign flag_wr     = flags.wr_side;

    p_mode_locked_r1: assert property (@(posedge clk) disable iff (rst)
        !rst |=> $stable(mode_q));

endmodule

// File: tb/test_dualmode_rd_stage.sv
module test_dualmode_rd_stage;

    localparam int DW    = 18;
    localparam int AW    = 3;
    localparam int DEPTH = 1 << AW;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          mode_pin = 1'b0;
    logic          wr_en_n = 1'b1;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en_n = 1'b1;
    logic          rd_cs_n = 1'b1;
    logic          mem_wr_en, mem_rd_en;
    logic [AW-1:0] mem_wr_addr, mem_rd_addr;
    logic [DW-1:0] mem_wr_data, mem_rd_data, rd_data;
    logic          flag_rd, flag_wr;

    logic [DW-1:0] mem_model [DEPTH];
    logic [DW-1:0] q [$];

    int checks = 0;
    int fails  = 0;

    always #2 clk = ~clk;

    always_ff @(posedge clk) begin
        if (mem_wr_en) mem_model[mem_wr_addr] <= mem_wr_data;
    end
    assign mem_rd_data = mem_model[mem_rd_addr];

    dualmode_rd_stage #(.DATA_W(DW), .ADDR_W(AW), .SYNC_STAGES(2)) i_dualmode_rd_stage (
        .clk(clk), .rst(rst), .mode_pin(mode_pin),
        .wr_en_n(wr_en_n), .wr_data(wr_data),
        .rd_en_n(rd_en_n), .rd_cs_n(rd_cs_n),
        .mem_wr_en(mem_wr_en), .mem_wr_addr(mem_wr_addr), .mem_wr_data(mem_wr_data),
        .mem_rd_en(mem_rd_en), .mem_rd_addr(mem_rd_addr), .mem_rd_data(mem_rd_data),
        .rd_data(rd_data), .flag_rd(flag_rd), .flag_wr(flag_wr)
    );

    // Expected flag levels from the requirements (R2, R3).
    function automatic logic exp_rd_flag(input bit fwft, input bit has_word);
        return fwft ? !has_word : has_word;
    endfunction

    function automatic logic exp_wr_flag(input bit fwft, input bit is_full);
        return fwft ? is_full : !is_full;
    endfunction

    function automatic logic [DW-1:0] word_of(input int n);
        return DW'((n * 37 + 5) ^ (n << 9));
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act,
                         input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic chk_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
        check(act == exp, req, act, exp);
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset(input bit m);
        rst = 1'b1; mode_pin = m;
        wr_en_n = 1'b1; rd_en_n = 1'b1; rd_cs_n = 1'b1;
        q.delete();
        repeat (3) tick();
        rst = 1'b0;
    endtask

    task automatic random_phase(input bit fwft, input int cycles, input int base);
        int n = base;
        for (int c = 0; c < cycles; c++) begin
            bit do_wr, do_rd, push, pop;
            logic [DW-1:0] popped;
            do_wr = ($urandom % 3) != 0;
            do_rd = ($urandom % 2) != 0;
            wr_en_n = !do_wr;
            wr_data = word_of(n);
            rd_en_n = ($urandom % 4) == 0 ? 1'b1 : !do_rd;
            rd_cs_n = ($urandom % 4) == 0;
            push = do_wr && (fwft ? !flag_wr : flag_wr);
            pop  = !rd_en_n && !rd_cs_n && (fwft ? !flag_rd : flag_rd);
            if (fwft && !flag_rd && q.size() > 0)
                chk_eq("R9 fwft order", rd_data, q[0]);
            popped = (pop && q.size() > 0) ? q.pop_front() : '0;
            if (push) begin
                q.push_back(word_of(n));
                n++;
            end
            tick();
            if (!fwft && pop) chk_eq("R9 std order", rd_data, popped);
        end
        wr_en_n = 1'b1; rd_en_n = 1'b1; rd_cs_n = 1'b1;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=%0d expected=%0d", 150000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd2024));
        @(negedge clk);

        // ---------------- explicit-read mode ----------------
        do_reset(1'b0);
        chk_eq("R2 reset flag_rd", flag_rd, exp_rd_flag(0, 0));
        chk_eq("R2 reset flag_wr", flag_wr, exp_wr_flag(0, 0));
        chk_eq("R2 reset rd_data", rd_data, 0);

        // R1: pin change after reset is ignored
        mode_pin = 1'b1;
        repeat (3) tick();
        chk_eq("R1 flag_rd after pin change", flag_rd, 0);
        chk_eq("R1 flag_wr after pin change", flag_wr, 1);

        // R6: read while empty
        rd_en_n = 0; rd_cs_n = 0;
        tick();
        rd_en_n = 1; rd_cs_n = 1;
        chk_eq("R6 read on empty keeps data", rd_data, 0);

        // R8: write, empty clears two edges later
        wr_en_n = 0; wr_data = 18'h2A5A5;
        tick();
        wr_en_n = 1;
        chk_eq("R8 flag_rd after write edge", flag_rd, 0);
        tick();
        chk_eq("R8 flag_rd one edge later", flag_rd, 0);
        tick();
        chk_eq("R8 flag_rd two edges later", flag_rd, 1);

        // R5: enable without select
        rd_en_n = 0; rd_cs_n = 1;
        tick();
        chk_eq("R5 no read without select", rd_data, 0);
        rd_en_n = 1; rd_cs_n = 0;
        tick();
        chk_eq("R5 no read without enable", rd_data, 0);
        chk_eq("R5 word still available", flag_rd, 1);

        // R10: true read loads on its edge
        rd_en_n = 0; rd_cs_n = 0;
        tick();
        rd_en_n = 1; rd_cs_n = 1;
        chk_eq("R10 read loads word", rd_data, 18'h2A5A5);
        chk_eq("R10 empty after last", flag_rd, 0);
        repeat (3) tick();

        // R2: fill eight slots
        for (int i = 0; i < DEPTH; i++) begin
            wr_en_n = 0; wr_data = word_of(100 + i);
            tick();
        end
        chk_eq("R2 full after eight", flag_wr, exp_wr_flag(0, 1));
        wr_data = 18'h3FFFF;           // R6: dropped write
        tick();
        wr_en_n = 1;
        repeat (3) tick();
        chk_eq("R6 still full", flag_wr, 0);

        // R8: full clears two edges after a read
        rd_en_n = 0; rd_cs_n = 0;
        tick();
        rd_en_n = 1; rd_cs_n = 1;
        chk_eq("R9 first of fill", rd_data, word_of(100));
        chk_eq("R8 flag_wr after read edge", flag_wr, 0);
        tick();
        chk_eq("R8 flag_wr one edge later", flag_wr, 0);
        tick();
        chk_eq("R8 flag_wr two edges later", flag_wr, 1);

        for (int i = 1; i < DEPTH; i++) begin
            rd_en_n = 0; rd_cs_n = 0;
            tick();
            chk_eq("R9 std drain order", rd_data, word_of(100 + i));
        end
        tick();
        rd_en_n = 1; rd_cs_n = 1;
        chk_eq("R6 dropped write never read", rd_data, word_of(100 + DEPTH - 1));
        chk_eq("R6 empty after drain", flag_rd, 0);

        random_phase(1'b0, 600, 1000);

        // ---------------- fall-through mode ----------------
        do_reset(1'b1);
        chk_eq("R3 reset flag_rd", flag_rd, exp_rd_flag(1, 0));
        chk_eq("R3 reset flag_wr", flag_wr, exp_wr_flag(1, 0));
        mode_pin = 1'b0;               // R1: ignored after reset

        wr_en_n = 0; wr_data = 18'h1C3C3;
        tick();
        wr_en_n = 1;
        tick();
        tick();
        chk_eq("R4 not yet at second edge", flag_rd, 1);
        tick();
        chk_eq("R4 ready at third edge", flag_rd, 0);
        chk_eq("R4 word fell through", rd_data, 18'h1C3C3);
        chk_eq("R1 mode held fwft", flag_wr, 0);

        rd_en_n = 0; rd_cs_n = 1;
        tick();
        chk_eq("R5 fwft hold valid", flag_rd, 0);
        chk_eq("R5 fwft hold data", rd_data, 18'h1C3C3);

        rd_en_n = 0; rd_cs_n = 0;
        tick();
        rd_en_n = 1; rd_cs_n = 1;
        chk_eq("R7 last read drives flag high", flag_rd, 1);
        chk_eq("R6 data kept after last read", rd_data, 18'h1C3C3);

        // R3: capacity is DEPTH+1
        for (int i = 0; i < DEPTH; i++) begin
            wr_en_n = 0; wr_data = word_of(200 + i);
            tick();
        end
        wr_en_n = 1;
        repeat (6) tick();
        chk_eq("R3 not full with one slot left", flag_wr, 0);
        wr_en_n = 0; wr_data = word_of(200 + DEPTH);
        tick();
        chk_eq("R3 full at depth plus one", flag_wr, 1);
        wr_data = 18'h3FFFF;           // R6: dropped
        tick();
        wr_en_n = 1;
        tick();

        for (int i = 0; i <= DEPTH; i++) begin
            chk_eq("R9 fwft drain order", rd_data, word_of(200 + i));
            chk_eq("R9 fwft valid during drain", flag_rd, 0);
            rd_en_n = 0; rd_cs_n = 0;
            tick();
            rd_en_n = 1; rd_cs_n = 1;
        end
        chk_eq("R7 empty after drain", flag_rd, 1);
        repeat (4) tick();
        chk_eq("R6 dropped write absent", flag_rd, 1);

        random_phase(1'b1, 600, 3000);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule